// File: doc/BRIEF.md
# Split-Half Register ALU

This block is the arithmetic and logic stage of a small 16-bit processor, together with its register file. The file holds four general registers. Any of them can be used as a full word, or its upper or lower byte can be used on its own. Each clock cycle the block may accept one operation. The operation names a destination register, a source register, a lane (full word, low byte or high byte) and an 8-bit immediate shift count. At the next clock edge it writes the result back into the destination and updates three condition flags: zero, signed overflow and equal. A later branch unit uses these flags.

The block covers add, subtract, AND, OR, XOR and compare in every lane. It also has invert and the two logical shifts per lane, and two whole-register operations: byte swap and sign extend. Compare only sets the flags. In a byte lane the byte that is not selected is written back unchanged. A separate combinational read port lets the surrounding core, or a bench, read any register.

Top module: `halfreg_alu`

## Requirements
- R1: After synchronous reset all four registers read 0, all three flags are 0 and `wb_valid` is 0.
- R2: Operation codes are NOP=0, ADD=1, SUB=2, AND=3, OR=4, XOR=5, CMP=6, INV=7, SHL=8, SHR=9, SWAB=10, SEXT=11. In the cycle after a writing operation is accepted, the new value appears on `wb_data` and on the read port, with `wb_valid` high and `wb_reg` equal to the destination. For binary operations the result is destination op source.
- R3: Lane select 0 and 3 mean full word, 1 means low byte (bits 7:0), 2 means high byte (bits 15:8). A byte-lane operation uses the same byte of both registers, and the other byte of the destination keeps its value.
- R4: CMP computes the same flags as SUB, writes no register and leaves `wb_valid` low.
- R5: The zero flag is set exactly when the result, in the selected width, is 0.
- R6: Overflow is signed two's-complement overflow in the selected width for ADD, SUB and CMP. AND, OR, XOR, INV, SHL, SHR, SWAB and SEXT clear it.
- R7: The equal flag is set by SUB and CMP when the two operands are equal in the selected width. All other defined operations clear it.
- R8: INV writes the bitwise complement of the selected lane of the destination.
- R9: SHL and SHR shift the selected lane of the destination by `shift_amt`. SHR is logical. A count equal to or larger than the lane width (8 or 16) gives 0.
- R10: SWAB exchanges the two bytes of the destination, and SEXT copies bit 7 into bits 15:8. Both ignore the lane select and compute their flags on 16 bits.
- R11: An operation with `op_valid` low, code NOP, or an undefined code 12 to 15 writes no register, keeps `wb_valid` low and leaves all flags unchanged.
- R12: When destination and source are the same register, both operands are the value held before the operation, so SUB of a register with itself gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code |
| lane_sel | input | 2 | Lane: 0/3 full, 1 low byte, 2 high byte |
| dst_sel | input | 2 | Destination register (first operand) |
| src_sel | input | 2 | Source register (second operand) |
| shift_amt | input | 8 | Immediate shift count |
| rd_sel | input | 2 | Read port register select |
| rd_data | output | 16 | Read port data (combinational) |
| wb_valid | output | 1 | A register was written at the last edge |
| wb_reg | output | 2 | Register written |
| wb_data | output | 16 | Full 16-bit value written |
| flag_zero | output | 1 | Zero flag |
| flag_ovf | output | 1 | Signed overflow flag |
| flag_eq | output | 1 | Equal flag |

## Verification
Two things can land on the same register in a single cycle: the writeback of one operation and the operand read of the next. The same holds when one register is both destination and source. The bench issues operations back to back with no idle cycles, often with dst equal to src, and moves the read port to the destination. After each edge a behavioural model predicts the merged 16-bit value and the flags, and the bench compares them with the block's outputs. A stale operand or a wrongly merged byte lane shows up there as a data mismatch.

// File: rtl/halfreg_alu_pkg.sv
package halfreg_alu_pkg;

    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 4;
    localparam int SEL_W    = $clog2(NUM_REGS);
    localparam int OP_W     = 4;
    localparam int SHAMT_W  = 8;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_CMP  = 4'd6,
        OP_INV  = 4'd7,
        OP_SHL  = 4'd8,
        OP_SHR  = 4'd9,
        OP_SWAB = 4'd10,
        OP_SEXT = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        LANE_FULL     = 2'd0,
        LANE_LO       = 2'd1,
        LANE_HI       = 2'd2,
        LANE_FULL_ALT = 2'd3
    } lane_e;

    typedef struct packed {
        logic zero;
        logic ovf;
        logic eq;
    } alu_flags_t;

    // operation changes the flags (every defined code except NOP)
    function automatic logic op_sets_flags(input logic [OP_W-1:0] op);
        return (op >= OP_ADD) && (op <= OP_SEXT);
    endfunction

    // operation writes a register
    function automatic logic op_writes_reg(input logic [OP_W-1:0] op);
        return op_sets_flags(op) && (op != OP_CMP);
    endfunction

    // operation always works on the whole word
    function automatic logic op_whole_word(input logic [OP_W-1:0] op);
        return (op == OP_SWAB) || (op == OP_SEXT);
    endfunction

endpackage

// File: rtl/halfreg_alu_regfile.sv
module halfreg_alu_regfile
    import halfreg_alu_pkg::*;
#(
    parameter int N = NUM_REGS,
    parameter int W = WORD_W,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    input  logic [AW-1:0] raddr_c,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b,
    output logic [W-1:0]  rdata_c
);

    logic [W-1:0] mem_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
    assign rdata_c = mem_q[raddr_c];

endmodule

// File: rtl/halfreg_alu_exec.sv
module halfreg_alu_exec
    import halfreg_alu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [OP_W-1:0]    op,
    input  logic [W-1:0]       opa,
    input  logic [W-1:0]       opb,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [W-1:0]       res,
    output alu_flags_t         flg
);

    localparam logic [SHAMT_W-1:0] SH_LIMIT = SHAMT_W'(W);

    logic [W-1:0] sum;
    logic [W-1:0] diff;
    logic         big_shift;

    assign sum       = opa + opb;
    assign diff      = opa - opb;
    assign big_shift = (shamt >= SH_LIMIT);

    always_comb begin
        res     = '0;
        flg.ovf = 1'b0;
        flg.eq  = 1'b0;
        case (op)
            OP_ADD: begin
                res     = sum;
                flg.ovf = (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);
            end
            OP_SUB, OP_CMP: begin
                res     = diff;
                flg.ovf = (opa[W-1] != opb[W-1]) && (diff[W-1] != opa[W-1]);
                flg.eq  = (opa == opb);
            end
            OP_AND:  res = opa & opb;
            OP_OR:   res = opa | opb;
            OP_XOR:  res = opa ^ opb;
            OP_INV:  res = ~opa;
            OP_SHL:  res = big_shift ? '0 : (opa << shamt);
            OP_SHR:  res = big_shift ? '0 : (opa >> shamt);
            default: res = '0;
        endcase
        flg.zero = (res == '0);
    end

endmodule

// File: rtl/halfreg_alu.sv
module halfreg_alu
    import halfreg_alu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic [OP_W-1:0]    op_code,
    input  logic [1:0]         lane_sel,
    input  logic [SEL_W-1:0]   dst_sel,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic [SHAMT_W-1:0] shift_amt,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [WORD_W-1:0]  rd_data,
    output logic               wb_valid,
    output logic [SEL_W-1:0]   wb_reg,
    output logic [WORD_W-1:0]  wb_data,
    output logic               flag_zero,
    output logic               flag_ovf,
    output logic               flag_eq
);

    logic [WORD_W-1:0] opa_full;
    logic [WORD_W-1:0] opb_full;
    logic [BYTE_W-1:0] opa_byte;
    logic [BYTE_W-1:0] opb_byte;
    logic [WORD_W-1:0] res_word;
    logic [BYTE_W-1:0] res_byte;
    alu_flags_t        flg_word;
    alu_flags_t        flg_byte;
    logic              lane_hi;
    logic              lane_is_byte;
    logic [WORD_W-1:0] new_val;
    alu_flags_t        new_flg;
    logic              do_write;
    logic              do_flags;

    logic              wb_valid_q;
    logic [SEL_W-1:0]  wb_reg_q;
    logic [WORD_W-1:0] wb_data_q;
    alu_flags_t        flags_q;

    halfreg_alu_regfile #(.N(NUM_REGS), .W(WORD_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (do_write),
        .waddr   (dst_sel),
        .wdata   (new_val),
        .raddr_a (dst_sel),
        .raddr_b (src_sel),
        .raddr_c (rd_sel),
        .rdata_a (opa_full),
        .rdata_b (opb_full),
        .rdata_c (rd_data)
    );

    assign lane_hi      = (lane_sel == LANE_HI);
    assign lane_is_byte = (lane_sel == LANE_LO) || lane_hi;
    assign opa_byte     = lane_hi ? opa_full[WORD_W-1:BYTE_W] : opa_full[BYTE_W-1:0];
    assign opb_byte     = lane_hi ? opb_full[WORD_W-1:BYTE_W] : opb_full[BYTE_W-1:0];

    halfreg_alu_exec #(.W(WORD_W)) u_exec_word (
        .op    (op_code),
        .opa   (opa_full),
        .opb   (opb_full),
        .shamt (shift_amt),
        .res   (res_word),
        .flg   (flg_word)
    );

    halfreg_alu_exec #(.W(BYTE_W)) u_exec_byte (
        .op    (op_code),
        .opa   (opa_byte),
        .opb   (opb_byte),
        .shamt (shift_amt),
        .res   (res_byte),
        .flg   (flg_byte)
    );

    // merge the lane result back into the 16-bit destination
    always_comb begin
        new_val = res_word;
        new_flg = flg_word;
        if (op_whole_word(op_code)) begin
            if (op_code == OP_SWAB) begin
                new_val = {opa_full[BYTE_W-1:0], opa_full[WORD_W-1:BYTE_W]};
            end else begin
                new_val = {{(WORD_W-BYTE_W){opa_full[BYTE_W-1]}}, opa_full[BYTE_W-1:0]};
            end
            new_flg.zero = (new_val == '0);
            new_flg.ovf  = 1'b0;
            new_flg.eq   = 1'b0;
        end else if (lane_is_byte) begin
            new_flg = flg_byte;
            if (lane_hi) begin
                new_val = {res_byte, opa_full[BYTE_W-1:0]};
            end else begin
                new_val = {opa_full[WORD_W-1:BYTE_W], res_byte};
            end
        end
    end

    assign do_write = op_valid && op_writes_reg(op_code);
    assign do_flags = op_valid && op_sets_flags(op_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid_q <= 1'b0;
            wb_reg_q   <= '0;
            wb_data_q  <= '0;
            flags_q    <= '0;
        end else begin
            wb_valid_q <= do_write;
            if (do_write) begin
                wb_reg_q  <= dst_sel;
                wb_data_q <= new_val;
            end
            if (do_flags) begin
                flags_q <= new_flg;
            end
        end
    end

    assign wb_valid  = wb_valid_q;
    assign wb_reg    = wb_reg_q;
    assign wb_data   = wb_data_q;
    assign flag_zero = flags_q.zero;
    assign flag_ovf  = flags_q.ovf;
    assign flag_eq   = flags_q.eq;

endmodule

// File: rtl/halfreg_alu_checker.sv
module halfreg_alu_checker
    import halfreg_alu_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               op_valid,
    input logic [OP_W-1:0]    op_code,
    input logic [1:0]         lane_sel,
    input logic [SEL_W-1:0]   dst_sel,
    input logic               wb_valid,
    input logic [SEL_W-1:0]   wb_reg,
    input logic [WORD_W-1:0]  wb_data,
    input logic               flag_zero,
    input logic               flag_ovf,
    input logic               flag_eq,
    input logic [WORD_W-1:0]  opa_full
);

    logic is_logic_op;
    logic byte_write;
    assign is_logic_op = (op_code == OP_AND) || (op_code == OP_OR) || (op_code == OP_XOR) ||
                         (op_code == OP_INV) || (op_code == OP_SHL) || (op_code == OP_SHR) ||
                         (op_code == OP_SWAB) || (op_code == OP_SEXT);
    assign byte_write = op_valid && op_writes_reg(op_code) && !op_whole_word(op_code);

    // R1
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wb_valid && !flag_zero && !flag_ovf && !flag_eq));

    // R2
    p_wb_target_r2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_writes_reg(op_code)) |=> (wb_valid && wb_reg == $past(dst_sel)));

    // R3
    p_keep_high_r3: assert property (@(posedge clk) disable iff (rst)
        (byte_write && lane_sel == LANE_LO) |=> (wb_data[15:8] == $past(opa_full[15:8])));

    p_keep_low_r3: assert property (@(posedge clk) disable iff (rst)
        (byte_write && lane_sel == LANE_HI) |=> (wb_data[7:0] == $past(opa_full[7:0])));

    // R4
    p_cmp_silent_r4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_CMP) |=> !wb_valid);

    // R6
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_logic_op) |=> !flag_ovf);

    // R7
    p_eq_source_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_eq) |-> $past(op_valid && (op_code == OP_SUB || op_code == OP_CMP)));

    // R10
    p_sext_fill_r10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_SEXT) |=> (wb_data[15:8] == {8{wb_data[7]}}));

    // R11
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || !op_sets_flags(op_code)) |=>
            (!wb_valid && $stable(flag_zero) && $stable(flag_ovf) && $stable(flag_eq)));

endmodule

bind halfreg_alu halfreg_alu_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .lane_sel  (lane_sel),
    .dst_sel   (dst_sel),
    .wb_valid  (wb_valid),
    .wb_reg    (wb_reg),
    .wb_data   (wb_data),
    .flag_zero (flag_zero),
    .flag_ovf  (flag_ovf),
    .flag_eq   (flag_eq),
    .opa_full  (opa_full)
);

// File: tb/halfreg_alu_bench.sv
module halfreg_alu_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [1:0]  lane_sel;
    logic [1:0]  dst_sel;
    logic [1:0]  src_sel;
    logic [7:0]  shift_amt;
    logic [1:0]  rd_sel;
    logic [15:0] rd_data;
    logic        wb_valid;
    logic [1:0]  wb_reg;
    logic [15:0] wb_data;
    logic        flag_zero;
    logic        flag_ovf;
    logic        flag_eq;

    int regs [4];
    int fz, fo, fe;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    halfreg_alu u_halfreg_alu (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .lane_sel  (lane_sel),
        .dst_sel   (dst_sel),
        .src_sel   (src_sel),
        .shift_amt (shift_amt),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .wb_valid  (wb_valid),
        .wb_reg    (wb_reg),
        .wb_data   (wb_data),
        .flag_zero (flag_zero),
        .flag_ovf  (flag_ovf),
        .flag_eq   (flag_eq)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_flags(input string tag);
        check(tag, "flag_zero", int'(flag_zero), fz);
        check(tag, "flag_ovf",  int'(flag_ovf),  fo);
        check(tag, "flag_eq",   int'(flag_eq),   fe);
    endtask

    // one operation: model prediction, drive, compare after the edge
    task automatic do_op(input string tag, input int op, input int dst, input int src,
                         input int lane, input int sh);
        bit full, wr, upd;
        int w, mask, a, b, r, ov, eq, nv;
        full = (lane == 0) || (lane == 3) || (op == 10) || (op == 11);
        w    = full ? 16 : 8;
        mask = (1 << w) - 1;
        a = full ? regs[dst] : ((lane == 1) ? (regs[dst] & 255) : ((regs[dst] >> 8) & 255));
        b = full ? regs[src] : ((lane == 1) ? (regs[src] & 255) : ((regs[src] >> 8) & 255));
        r = 0; ov = 0; eq = 0;
        upd = (op >= 1) && (op <= 11);
        wr  = upd && (op != 6);
        case (op)
            1: begin r = (a + b) & mask; ov = (((a ^ r) & (b ^ r)) >> (w - 1)) & 1; end
            2, 6: begin
                r = (a - b) & mask; ov = (((a ^ b) & (a ^ r)) >> (w - 1)) & 1;
                eq = (a == b) ? 1 : 0;
            end
            3: r = a & b;
            4: r = a | b;
            5: r = a ^ b;
            7: r = (~a) & mask;
            8: r = (sh >= w) ? 0 : ((a << sh) & mask);
            9: r = (sh >= w) ? 0 : (a >> sh);
            10: r = ((a & 255) << 8) | ((a >> 8) & 255);
            11: r = (a & 255) | (((a & 128) != 0) ? 32'hff00 : 0);
            default: r = 0;
        endcase
        if (full)           nv = r;
        else if (lane == 1) nv = (regs[dst] & 32'hff00) | r;
        else                nv = (regs[dst] & 255) | (r << 8);
        @(negedge clk);
        op_valid  = 1'b1;
        op_code   = 4'(op);
        dst_sel   = 2'(dst);
        src_sel   = 2'(src);
        lane_sel  = 2'(lane);
        shift_amt = 8'(sh);
        rd_sel    = 2'(dst);
        @(posedge clk);
        #1;
        check(tag, "wb_valid", int'(wb_valid), int'(wr));
        if (wr) begin
            regs[dst] = nv;
            check(tag, "wb_reg", int'(wb_reg), dst);
            check(tag, "wb_data", int'(wb_data), nv);
        end
        if (upd) begin
            fz = (r == 0) ? 1 : 0;
            fo = ov;
            fe = eq;
        end
        check_flags(tag);
        check(tag, "rd_data", int'(rd_data), regs[dst]);
    endtask

    task automatic idle(input string tag, input int dst);
        @(negedge clk);
        op_valid = 1'b0;
        op_code  = 4'd1;
        rd_sel   = 2'(dst);
        @(posedge clk);
        #1;
        check(tag, "wb_valid", int'(wb_valid), 0);
        check_flags(tag);
        check(tag, "rd_data", int'(rd_data), regs[dst]);
    endtask

    // builds a constant in register dst using ops only; register 3 must hold 1
    task automatic load(input int dst, input int val);
        do_op("R12", 2, dst, dst, 0, 0);
        for (int i = 15; i >= 0; i--) begin
            do_op("R9", 8, dst, dst, 0, 1);
            if (((val >> i) & 1) != 0) do_op("R2", 4, dst, 3, 0, 0);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) regs[i] = 0;
        fz = 0; fo = 0; fe = 0;
        rst = 1'b1; op_valid = 1'b0; op_code = '0; lane_sel = '0;
        dst_sel = '0; src_sel = '0; shift_amt = '0; rd_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rd_sel = 2'(i);
            #1;
            check("R1", "rd_data", int'(rd_data), 0);
        end
        check("R1", "wb_valid", int'(wb_valid), 0);
        check_flags("R1");

        // D = 1 through invert and a wide right shift
        do_op("R8", 7, 3, 3, 0, 0);
        do_op("R9", 9, 3, 3, 0, 15);
        // signed overflow on 16 bits
        load(0, 16'h7fff);
        load(1, 16'h0001);
        do_op("R6", 1, 0, 1, 0, 0);
        do_op("R6", 2, 0, 1, 3, 0);
        do_op("R12", 2, 0, 0, 0, 0);
        do_op("R5", 1, 0, 0, 0, 0);
        do_op("R4", 6, 1, 3, 0, 0);
        do_op("R7", 6, 1, 3, 0, 0);
        do_op("R7", 3, 1, 3, 0, 0);
        // byte lanes
        load(0, 16'h12f0);
        load(1, 16'h3415);
        do_op("R3", 1, 0, 1, 1, 0);
        do_op("R3", 1, 0, 1, 2, 0);
        do_op("R3", 2, 1, 0, 1, 0);
        do_op("R3", 5, 0, 1, 2, 0);
        load(2, 16'h7f80);
        do_op("R6", 1, 2, 2, 2, 0);
        do_op("R6", 2, 2, 1, 1, 0);
        do_op("R4", 6, 0, 0, 2, 0);
        do_op("R8", 7, 0, 0, 2, 0);
        do_op("R8", 7, 1, 1, 1, 0);
        // shifts and their limits
        load(0, 16'hc3a5);
        do_op("R9", 8, 0, 0, 1, 3);
        do_op("R9", 9, 0, 0, 2, 7);
        do_op("R9", 8, 0, 0, 2, 8);
        do_op("R9", 9, 0, 0, 0, 4);
        do_op("R9", 8, 0, 0, 0, 16);
        load(1, 16'h8001);
        do_op("R9", 9, 1, 1, 0, 200);
        // whole-word ops ignore lane
        load(2, 16'h1280);
        do_op("R10", 10, 2, 2, 1, 0);
        do_op("R10", 11, 2, 2, 2, 0);
        do_op("R10", 11, 2, 2, 0, 0);
        // ignored operations
        load(1, 16'h0101);
        do_op("R11", 0, 1, 1, 0, 0);
        do_op("R11", 13, 1, 1, 1, 0);
        do_op("R11", 15, 1, 3, 0, 0);
        idle("R11", 1);
        // back-to-back mixed traffic, often dst == src
        for (int n = 0; n < 600; n++) begin
            int op, d, s, ln, sh;
            op = $urandom_range(15);
            d  = $urandom_range(3);
            s  = ($urandom_range(3) == 0) ? d : $urandom_range(3);
            ln = $urandom_range(3);
            sh = ($urandom_range(9) == 0) ? $urandom_range(255) : $urandom_range(17);
            if (op != 0 && op < 12) do_op("R2", op, d, s, ln, sh);
            else do_op("R11", op, d, s, ln, sh);
            if ($urandom_range(19) == 0) idle("R11", d);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule